// File: doc/BRIEF.md
# BCD Seven-Segment Latch Decoder

This block turns a 4-bit binary-coded decimal digit into the seven segment drive levels of a numeric display. A storage register holds the digit. While the load control is high it follows the data input on every clock edge. While the load control is low it keeps the last code it took in, so the data bus can be shared or left undriven.

The held code is decoded to segments a through g. Codes above nine give an empty digit. A blanking control forces every segment off. A polarity control inverts all seven outputs, blanked states included. With polarity low the outputs suit common-cathode LEDs, and with polarity high they suit common-anode LEDs. For a liquid-crystal panel, the polarity input is toggled by the same square wave that drives the backplane, so a lit segment is in antiphase with the backplane.

All three controls act in one registered output stage. Every input change reaches the segment pins exactly one clock later, and the outputs are free of glitches.

Top module: `seg_latch_decoder`

## Requirements
- R1: While rst_ni is low, seg_o is 0000000 and the stored code is cleared to 0. The first edge after release with le_i low, bl_i low and ph_i low shows digit 0.
- R2: With le_i high, the code on bcd_i is stored at the rising clock edge, and its pattern appears on seg_o right after that same edge.
- R3: With le_i low, the stored code does not change whatever bcd_i does. With bl_i and ph_i steady, seg_o is steady.
- R4: seg_o bit 6 is segment a and bit 0 is segment g. With ph_i low and bl_i low, the codes 0..9 give 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111 and 1111011. Digits 6 and 9 are the tailed forms.
- R5: Stored codes 10 to 15 give all segments off (0000000 with ph_i low).
- R6: With bl_i high, every segment is off one edge later, whatever le_i and bcd_i are. The register still loads when le_i is high, so the new digit shows once blanking is released.
- R7: With ph_i high, seg_o is the bitwise inverse of the value it would have with ph_i low. This includes the blanked and out-of-range cases, which give 1111111.
- R8: bcd_i is weighted 8-4-2-1, with bcd_i[0] the least significant bit and bcd_i[3] the most significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| le_i | input | 1 | Load control: high follows bcd_i, low holds the stored code |
| bl_i | input | 1 | Blanking, active high |
| ph_i | input | 1 | Output polarity: high inverts all segments |
| bcd_i | input | 4 | BCD digit, bit 0 least significant |
| seg_o | output | 7 | Segments a (bit 6) to g (bit 0) |

## Verification
The bench goes after the corner cases where a wrong design is hard to spot on a display.

A decoder that showed hex letters for codes 10 to 15 would light segments where R5 wants a dark digit. Untailed 6 or 9 glyphs would drop segment a or segment d. A reversed bit weighting would swap 1 with 8 and 2 with 4.

A register that kept loading with le_i low would let the digit follow the bus. If blanking stopped the register from loading, the old digit would come back after blanking is released. If the inversion skipped the blanked path, an LCD would show a stuck-on digit as all-dark, or the reverse.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SEG_W     = 7;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;
endpackage

// File: rtl/bcd_store.sv
module bcd_store
  import seg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  le_i,
  input  code_t d_i,
  output code_t next_o
);
  code_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (le_i) code_q <= d_i;
  end

  // code that will be held after this edge; feeds the output stage directly
  assign next_o = le_i ? d_i : code_q;
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  pat_o
);
  // bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (code_i)
      4'd0:    pat_o = 7'b1111110;
      4'd1:    pat_o = 7'b0110000;
      4'd2:    pat_o = 7'b1101101;
      4'd3:    pat_o = 7'b1111001;
      4'd4:    pat_o = 7'b0110011;
      4'd5:    pat_o = 7'b1011011;
      4'd6:    pat_o = 7'b1011111;
      4'd7:    pat_o = 7'b1110000;
      4'd8:    pat_o = 7'b1111111;
      4'd9:    pat_o = 7'b1111011;
      default: pat_o = '0;
    endcase
  end
endmodule

// File: rtl/seg_drive.sv
module seg_drive
  import seg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  seg_t pat_i,
  input  logic bl_i,
  input  logic ph_i,
  output seg_t seg_o
);
  seg_t nxt;
  seg_t seg_q;

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    assign nxt[i] = (pat_i[i] & ~bl_i) ^ ph_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_q <= '0;
    else         seg_q <= nxt;
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/seg_latch_decoder.sv
module seg_latch_decoder
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              bl_i,
  input  logic              ph_i,
  input  logic [CODE_W-1:0] bcd_i,
  output logic [SEG_W-1:0]  seg_o
);
  code_t code_next;
  seg_t  pat;

  bcd_store i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .d_i    (bcd_i),
    .next_o (code_next)
  );

  seg_decode i_decode (
    .code_i (code_next),
    .pat_o  (pat)
  );

  seg_drive i_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pat_i  (pat),
    .bl_i   (bl_i),
    .ph_i   (ph_i),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/seg_latch_decoder_chk.sv
module seg_latch_decoder_chk
  import seg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              le_i,
  input logic              bl_i,
  input logic              ph_i,
  input logic [CODE_W-1:0] bcd_i,
  input logic [SEG_W-1:0]  seg_o
);
  logic started;
  logic bl_d, ph_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started <= 1'b0;
      bl_d    <= 1'b0;
      ph_d    <= 1'b0;
    end else begin
      started <= 1'b1;
      bl_d    <= bl_i;
      ph_d    <= ph_i;
    end
  end

  always_comb begin
    if (!rst_ni) p_reset_r1: assert (seg_o == '0);
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started && !le_i && bl_i == bl_d && ph_i == ph_d |=> $stable(seg_o));

  p_eight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i && !bl_i && !ph_i && bcd_i == 4'd8 |=> seg_o == 7'b1111111);

  p_high_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i && !bl_i && !ph_i && bcd_i > 4'(MAX_DIGIT) |=> seg_o == '0);

  p_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_i && !ph_i |=> seg_o == '0);

  p_blank_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_i && ph_i |=> seg_o == '1);
endmodule

bind seg_latch_decoder seg_latch_decoder_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .le_i   (le_i),
  .bl_i   (bl_i),
  .ph_i   (ph_i),
  .bcd_i  (bcd_i),
  .seg_o  (seg_o)
);

// File: tb/test_seg_latch_decoder.sv
module test_seg_latch_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       le_i = 1'b0, bl_i = 1'b0, ph_i = 1'b0;
  logic [3:0] bcd_i = '0;
  logic [6:0] seg_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_code = '0;

  always #5 clk_i = ~clk_i;

  seg_latch_decoder i_seg_latch_decoder (
    .clk_i (clk_i), .rst_ni (rst_ni), .le_i (le_i), .bl_i (bl_i),
    .ph_i (ph_i), .bcd_i (bcd_i), .seg_o (seg_o)
  );

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'b1111110;
      4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;
      4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;
      4'd5: return 7'b1011011;
      4'd6: return 7'b1011111;
      4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic [3:0] c, input logic bl, input logic ph);
    logic [6:0] v;
    v = bl ? 7'b0 : glyph(c);
    return ph ? ~v : v;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: seg_o=%b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge, expect result right after the next rising edge
  task automatic step(input logic le, input logic bl, input logic ph,
                      input logic [3:0] d, input string req);
    le_i = le; bl_i = bl; ph_i = ph; bcd_i = d;
    @(posedge clk_i);
    if (le) m_code = d;
    @(negedge clk_i);
    check(req, seg_o, expect_seg(m_code, bl, ph));
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4543));
    repeat (2) @(negedge clk_i);
    check("R1 reset", seg_o, 7'b0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'd9, "R1 cleared code shows 0");

    for (int c = 0; c < 16; c++) step(1'b1, 1'b0, 1'b0, 4'(c), "R2 R4 R5 R8 sweep ph low");
    for (int c = 0; c < 16; c++) step(1'b1, 1'b0, 1'b1, 4'(c), "R7 sweep ph high");
    step(1'b1, 1'b0, 1'b0, 4'b0001, "R8 lsb weight");
    step(1'b1, 1'b0, 1'b0, 4'b1000, "R8 msb weight");

    step(1'b1, 1'b0, 1'b0, 4'd7, "R2 load 7");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 4'($urandom), "R3 hold");
    step(1'b0, 1'b0, 1'b1, 4'd2, "R3 R7 hold inverted");

    step(1'b1, 1'b1, 1'b0, 4'd3, "R6 blank while loading");
    step(1'b0, 1'b0, 1'b0, 4'd5, "R6 loaded under blank");
    step(1'b1, 1'b1, 1'b1, 4'd6, "R6 R7 blank inverted");
    step(1'b1, 1'b0, 1'b0, 4'd12, "R5 code 12");

    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'(($urandom % 5) == 0), 1'($urandom), 4'($urandom), "R2 R3 R6 R7 random");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule